// File: doc/BRIEF.md
# CAN Node Error State Tracker

This block turns the controller's 8-bit error-flag snapshot into the node's fault-confinement state: error-active, warning, passive or bus-off. On every evaluation strobe the flags are decoded by a fixed priority, the new state is registered, and an event record is raised. The record carries a class code (controller problem and/or bus-off) and a detail code naming the source of the condition. Escalation and receive-overflow statistics are kept in saturating counters.

Whenever the observed flags are nonzero, the block issues a masked clear request. The mask is the observed flag value itself, so only the bits that were actually seen get cleared. If the node goes bus-off while automatic restart is disabled, the tracker freezes, ignores further evaluations and holds a sleep request until reset. The error counters and flag generation sit outside this block and arrive as inputs.

Top module: `can_err_tracker`

## Requirements
- R1: After reset the state is error-active (code 0). All counters are zero, and `evt_valid`, `clr_valid` and `sleep_req` are low.
- R2: One cycle after a strobe, `state` holds the highest-priority condition in the flags. Flag bit positions: bit1 receive warning, bit2 transmit warning, bit3 receive passive, bit4 transmit passive, bit5 bus-off. Priority, highest first: bus-off (3), transmit passive (2), receive passive (2), transmit warning (1), receive warning (1). With none of these set, the state is active (0), including when only bit0 (any-warning) is set. Without a strobe, the state holds.
- R3: `warn_cnt` increments by one when the state moves from active to warning, passive or bus-off.
- R4: `pass_cnt` increments by one when the state moves from active or warning to passive or bus-off. A direct jump from active to passive or bus-off increments both `warn_cnt` and `pass_cnt`.
- R5: `evt_detail` is one-hot over its low four bits and names the deciding source when the state is warning or passive: bit0 receive warning, bit1 transmit warning, bit2 receive passive, bit3 transmit passive. It is zero in those bits for active and bus-off.
- R6: Flag bit6 (overflow, buffer 0) and bit7 (overflow, buffer 1) each add one to both `ovf_cnt` and `rxerr_cnt`. Either bit sets `evt_detail` bit4.
- R7: A strobe with nonzero flags gives a one-cycle `clr_valid` in the next cycle, with `clr_mask` equal to the observed flags. A strobe with zero flags gives no clear.
- R8: A strobe that yields bus-off while `auto_restart_en` is low registers bus-off and raises `sleep_req`. The tracker then ignores all strobes (no state change, event, clear or count) until reset. With `auto_restart_en` high, evaluation continues.
- R9: Counters saturate at their all-ones value instead of wrapping. `stat_clear` zeroes them in the next cycle.
- R10: `evt_class` has bit0 set for warning, passive or overflow, and bit1 set for bus-off. `evt_valid` pulses for one cycle, in the same cycle the new state appears, whenever the class is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_valid | input | 1 | Evaluation strobe for `flag_byte` |
| flag_byte | input | 8 | Error-flag snapshot |
| auto_restart_en | input | 1 | Automatic bus-off restart enabled |
| stat_clear | input | 1 | Synchronous clear of the statistics counters |
| state | output | 2 | Error state: 0 active, 1 warning, 2 passive, 3 bus-off |
| evt_valid | output | 1 | Event record strobe |
| evt_class | output | 2 | Event class bits |
| evt_detail | output | 5 | Event detail bits |
| clr_valid | output | 1 | Masked flag clear request |
| clr_mask | output | 8 | Bits to clear |
| sleep_req | output | 1 | Halted on bus-off, sleep requested |
| warn_cnt | output | CNT_W | Warning escalation count |
| pass_cnt | output | CNT_W | Passive escalation count |
| ovf_cnt | output | CNT_W | Receive overflow count |
| rxerr_cnt | output | CNT_W | Total receive error count |

## Verification
The flag patterns include single state bits, which confirm each source's own state and detail code. Mixed words such as transmit-passive plus both warnings, or receive passive plus receive warning, confirm that the higher-priority source wins. Walking through active, warning, passive, warning, bus-off and active again separates a fall-through jump, which counts twice, from a step, which counts once, and from a de-escalation, which counts nothing. Words holding only the any-warning bit, or nothing at all, separate "clear but stay active" from "no clear". Repeated double-overflow words drive a narrowed counter into saturation. A bus-off with restart disabled, followed by a warning word, shows that the frozen tracker ignores input.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_WARNING = 2'd1,
    ST_PASSIVE = 2'd2,
    ST_BUSOFF  = 2'd3
  } err_state_t;

  localparam int FLAG_W   = 8;
  localparam int DETAIL_W = 5;
  localparam int CLASS_W  = 2;

  // flag bit positions (decoded by behaviour)
  localparam int F_ANYWARN = 0;
  localparam int F_RXWARN  = 1;
  localparam int F_TXWARN  = 2;
  localparam int F_RXPASS  = 3;
  localparam int F_TXPASS  = 4;
  localparam int F_BUSOFF  = 5;
  localparam int F_OVF0    = 6;
  localparam int F_OVF1    = 7;

  // detail bit positions
  localparam int D_RXWARN = 0;
  localparam int D_TXWARN = 1;
  localparam int D_RXPASS = 2;
  localparam int D_TXPASS = 3;
  localparam int D_OVF    = 4;

  // class bit positions
  localparam int C_CTRL   = 0;
  localparam int C_BUSOFF = 1;
endpackage

// File: rtl/can_err_classify.sv
module can_err_classify
  import can_err_pkg::*;
(
  input  logic [FLAG_W-1:0]   flags,
  output err_state_t          nxt_state,
  output logic [CLASS_W-1:0]  cls,
  output logic [DETAIL_W-1:0] detail,
  output logic [1:0]          ovf_hits
);
  logic any_ovf;

  always_comb begin
    detail    = '0;
    cls       = '0;
    nxt_state = ST_ACTIVE;
    if (flags[F_BUSOFF]) begin
      nxt_state        = ST_BUSOFF;
      cls[C_BUSOFF]    = 1'b1;
    end else if (flags[F_TXPASS]) begin
      nxt_state        = ST_PASSIVE;
      detail[D_TXPASS] = 1'b1;
    end else if (flags[F_RXPASS]) begin
      nxt_state        = ST_PASSIVE;
      detail[D_RXPASS] = 1'b1;
    end else if (flags[F_TXWARN]) begin
      nxt_state        = ST_WARNING;
      detail[D_TXWARN] = 1'b1;
    end else if (flags[F_RXWARN]) begin
      nxt_state        = ST_WARNING;
      detail[D_RXWARN] = 1'b1;
    end
    any_ovf        = flags[F_OVF0] | flags[F_OVF1];
    detail[D_OVF]  = any_ovf;
    cls[C_CTRL]    = any_ovf | (nxt_state == ST_WARNING) | (nxt_state == ST_PASSIVE);
    ovf_hits       = {1'b0, flags[F_OVF0]} + {1'b0, flags[F_OVF1]};
  end
endmodule

// File: rtl/can_err_escalate.sv
module can_err_escalate
  import can_err_pkg::*;
(
  input  err_state_t prev_state,
  input  err_state_t nxt_state,
  output logic       warn_inc,
  output logic       pass_inc
);
  logic from_active, from_low, to_warn_up, to_pass_up;

  always_comb begin
    from_active = (prev_state == ST_ACTIVE);
    from_low    = (prev_state == ST_ACTIVE) | (prev_state == ST_WARNING);
    to_warn_up  = (nxt_state != ST_ACTIVE);
    to_pass_up  = (nxt_state == ST_PASSIVE) | (nxt_state == ST_BUSOFF);
    // fall-through: a jump from active to passive counts in both
    warn_inc    = from_active & to_warn_up;
    pass_inc    = from_low & to_pass_up;
  end
endmodule

// File: rtl/can_sat_counter.sv
module can_sat_counter #(
  parameter int W      = 32,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [STEP_W-1:0] step,
  output logic [W-1:0]      cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;
  logic         cnt_en;

  always_comb begin
    sum    = {1'b0, cnt_q} + {{(W+1-STEP_W){1'b0}}, step};
    cnt_en = clr | en;
    if (clr)
      cnt_d = '0;
    else if (sum[W])
      cnt_d = MAXV;
    else
      cnt_d = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt_q >= $past(cnt_q));
  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/can_err_tracker.sv
module can_err_tracker
  import can_err_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flag_valid,
  input  logic [7:0]          flag_byte,
  input  logic                auto_restart_en,
  input  logic                stat_clear,
  output logic [1:0]          state,
  output logic                evt_valid,
  output logic [1:0]          evt_class,
  output logic [4:0]          evt_detail,
  output logic                clr_valid,
  output logic [7:0]          clr_mask,
  output logic                sleep_req,
  output logic [CNT_W-1:0]    warn_cnt,
  output logic [CNT_W-1:0]    pass_cnt,
  output logic [CNT_W-1:0]    ovf_cnt,
  output logic [CNT_W-1:0]    rxerr_cnt
);
  localparam int N_CNT = 4;

  err_state_t          state_q, state_d, c_state;
  logic [CLASS_W-1:0]  c_cls, cls_q, cls_d;
  logic [DETAIL_W-1:0] c_detail, det_q, det_d;
  logic [1:0]          c_ovf;
  logic                evt_q, evt_d, clr_q, clr_d, halt_q, halt_d;
  logic [FLAG_W-1:0]   mask_q, mask_d;
  logic                eval_go, rec_en, warn_inc, pass_inc;
  logic                cnt_en  [N_CNT];
  logic [1:0]          cnt_step[N_CNT];
  logic [CNT_W-1:0]    cnt_val [N_CNT];

  can_err_classify u_cls (
    .flags    (flag_byte),
    .nxt_state(c_state),
    .cls      (c_cls),
    .detail   (c_detail),
    .ovf_hits (c_ovf)
  );

  can_err_escalate u_esc (
    .prev_state(state_q),
    .nxt_state (c_state),
    .warn_inc  (warn_inc),
    .pass_inc  (pass_inc)
  );

  always_comb begin
    eval_go = flag_valid & ~halt_q;
    rec_en  = eval_go;
    state_d = eval_go ? c_state : state_q;
    evt_d   = eval_go & (c_cls != '0);
    clr_d   = eval_go & (flag_byte != '0);
    cls_d   = c_cls;
    det_d   = c_detail;
    mask_d  = flag_byte;
    halt_d  = halt_q | (eval_go & (c_state == ST_BUSOFF) & ~auto_restart_en);
    cnt_en[0]   = eval_go & warn_inc;
    cnt_step[0] = 2'd1;
    cnt_en[1]   = eval_go & pass_inc;
    cnt_step[1] = 2'd1;
    cnt_en[2]   = eval_go & (c_ovf != 2'd0);
    cnt_step[2] = c_ovf;
    cnt_en[3]   = eval_go & (c_ovf != 2'd0);
    cnt_step[3] = c_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      evt_q   <= 1'b0;
      clr_q   <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      evt_q   <= evt_d;
      clr_q   <= clr_d;
      halt_q  <= halt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q  <= '0;
      det_q  <= '0;
      mask_q <= '0;
    end else if (rec_en) begin
      cls_q  <= cls_d;
      det_q  <= det_d;
      mask_q <= mask_d;
    end
  end

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    can_sat_counter #(.W(CNT_W), .STEP_W(2)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (stat_clear),
      .en   (cnt_en[g]),
      .step (cnt_step[g]),
      .cnt  (cnt_val[g])
    );
  end

  assign state      = state_q;
  assign evt_valid  = evt_q;
  assign evt_class  = cls_q;
  assign evt_detail = det_q;
  assign clr_valid  = clr_q;
  assign clr_mask   = mask_q;
  assign sleep_req  = halt_q;
  assign warn_cnt   = cnt_val[0];
  assign pass_cnt   = cnt_val[1];
  assign ovf_cnt    = cnt_val[2];
  assign rxerr_cnt  = cnt_val[3];

  assert_state_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_valid |=> $stable(state_q));
  assert_detail_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(c_detail[3:0]));
  assert_clear_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && !halt_q && flag_byte != 8'h00) |=> (clr_q && mask_q == $past(flag_byte)));
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> (halt_q && $stable(state_q) && !evt_q && !clr_q));
  assert_halt_busoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> state_q == ST_BUSOFF);
  assert_evt_follows_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> $past(flag_valid));
endmodule

// File: tb/sim_can_err_tracker.sv
module sim_can_err_tracker;
  localparam int W = 4;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n, flag_valid, auto_restart_en, stat_clear;
  logic [7:0] flag_byte;
  logic [1:0] state, evt_class;
  logic [4:0] evt_detail;
  logic evt_valid, clr_valid, sleep_req;
  logic [7:0] clr_mask;
  logic [W-1:0] warn_cnt, pass_cnt, ovf_cnt, rxerr_cnt;

  int n_chk = 0, n_fail = 0;
  int ew = 0, ep = 0, eo = 0, er = 0;
  bit done = 0;

  always #4 clk = ~clk;

  can_err_tracker #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .flag_valid(flag_valid), .flag_byte(flag_byte),
    .auto_restart_en(auto_restart_en), .stat_clear(stat_clear),
    .state(state), .evt_valid(evt_valid), .evt_class(evt_class),
    .evt_detail(evt_detail), .clr_valid(clr_valid), .clr_mask(clr_mask),
    .sleep_req(sleep_req), .warn_cnt(warn_cnt), .pass_cnt(pass_cnt),
    .ovf_cnt(ovf_cnt), .rxerr_cnt(rxerr_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sat(input int v, input int d);
    return (v + d > MAXC) ? MAXC : v + d;
  endfunction

  task automatic check_counters(input string tag);
    check({tag, " R3 warn_cnt"}, warn_cnt, ew);
    check({tag, " R4 pass_cnt"}, pass_cnt, ep);
    check({tag, " R6 ovf_cnt"}, ovf_cnt, eo);
    check({tag, " R6 rxerr_cnt"}, rxerr_cnt, er);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; flag_valid = 1'b0; flag_byte = 8'h00;
    auto_restart_en = 1'b1; stat_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ew = 0; ep = 0; eo = 0; er = 0;
  endtask

  // one evaluation, checked in the cycle the registered result appears
  task automatic step(input logic [7:0] f, input int st, input int cls,
                      input int det, input int dw, input int dp, input int dov);
    @(negedge clk);
    flag_valid = 1'b1; flag_byte = f;
    @(negedge clk);
    flag_valid = 1'b0;
    ew = sat(ew, dw); ep = sat(ep, dp); eo = sat(eo, dov); er = sat(er, dov);
    check("R2 state", state, st);
    check("R10 evt_valid", evt_valid, (cls != 0));
    if (cls != 0) begin
      check("R10 evt_class", evt_class, cls);
      check("R5 R6 evt_detail", evt_detail, det);
    end
    check("R7 clr_valid", clr_valid, (f != 0));
    if (f != 0) check("R7 clr_mask", clr_mask, f);
    check_counters("step");
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 state", state, 0);
    check("R1 evt_valid", evt_valid, 0);
    check("R1 clr_valid", clr_valid, 0);
    check("R1 sleep_req", sleep_req, 0);
    check_counters("R1");
  endtask

  task automatic t_escalation();
    step(8'h00, 0, 0, 0, 0, 0, 0);
    step(8'h04, 1, 1, 5'h02, 1, 0, 0);   // R3 active->warning
    step(8'h02, 1, 1, 5'h01, 0, 0, 0);   // R5 rx warn source
    step(8'h08, 2, 1, 5'h04, 0, 1, 0);   // R4 warning->passive
    step(8'h00, 0, 0, 0, 0, 0, 0);
    step(8'h10, 2, 1, 5'h08, 1, 1, 0);   // R4 jump counts both
    step(8'h1E, 2, 1, 5'h08, 0, 0, 0);   // R2 tx passive wins
    step(8'h0A, 2, 1, 5'h04, 0, 0, 0);   // R2 rx passive over rx warn
    step(8'h06, 1, 1, 5'h02, 0, 0, 0);   // R3 de-escalation counts nothing
    step(8'h20, 3, 2, 5'h00, 0, 1, 0);   // R8 bus-off with restart on
    check("R8 no sleep with restart", sleep_req, 0);
    step(8'h00, 0, 0, 0, 0, 0, 0);
    // R10 event lasts one cycle
    step(8'h84, 1, 1, 5'h12, 1, 0, 1);   // R6 overflow with tx warn
    @(negedge clk);
    check("R10 evt pulse ends", evt_valid, 0);
    check("R7 clr pulse ends", clr_valid, 0);
    check("R2 state holds", state, 1);
  endtask

  task automatic t_anywarn();
    do_reset();
    step(8'h01, 0, 0, 0, 0, 0, 0);       // R2 any-warning alone stays active, R7 clears
    step(8'h00, 0, 0, 0, 0, 0, 0);       // R7 no clear for zero flags
  endtask

  task automatic t_saturate();
    do_reset();
    step(8'h40, 0, 1, 5'h10, 0, 0, 1);   // R6 single overflow bit
    for (int i = 0; i < 8; i++)
      step(8'hC0, 0, 1, 5'h10, 0, 0, 2); // R9 reaches saturation
    check("R9 ovf saturated", ovf_cnt, MAXC);
    check("R9 rxerr saturated", rxerr_cnt, MAXC);
    step(8'h10, 2, 1, 5'h08, 1, 1, 0);
    @(negedge clk); stat_clear = 1'b1;
    @(negedge clk); stat_clear = 1'b0;
    ew = 0; ep = 0; eo = 0; er = 0;
    check_counters("R9 clear");
  endtask

  task automatic t_halt();
    do_reset();
    auto_restart_en = 1'b0;
    step(8'h04, 1, 1, 5'h02, 1, 0, 0);
    step(8'h60, 3, 3, 5'h10, 0, 1, 1);   // R8 bus-off with overflow
    check("R8 sleep_req", sleep_req, 1);
    @(negedge clk);
    flag_valid = 1'b1; flag_byte = 8'h84;
    @(negedge clk);
    flag_valid = 1'b0;
    check("R8 ignored state", state, 3);
    check("R8 ignored evt", evt_valid, 0);
    check("R8 ignored clr", clr_valid, 0);
    check("R8 still sleeping", sleep_req, 1);
    check_counters("R8 ignored");
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_escalation();
    t_anywarn();
    t_saturate();
    t_halt();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule